// File: doc/BRIEF.md
# Three-Destination Interrupt Aggregator

This block gathers 31 level-sensitive hardware interrupt requests and one software-raised interrupt, and drives three level outputs: a host line that downstream logic may redirect, a host line that is never redirected, and a line to an on-chip management processor. Each destination owns a status view, a per-bit mask, a two-bit coarse enable (hardware group and software bit) and a read-only line-status word, all reached through a simple 32-bit register port with combinational read data and single-cycle writes.

Some request sources provide a second, private request wire for the non-redirected destination. A parameter selects which input positions do so; at those positions the non-redirected destination listens to the private wire, while the other two destinations always listen to the shared wire. Each destination's software bit is set or cleared by writing status bit 31. On the redirectable host and management destinations a set needs mask bit 31 to be 1; on the non-redirected destination mask bit 31 is not implemented and the software bit can be set without it.

Software drives the block by programming masks and enables, reading status to find the raiser, and writing status bit 31 to raise or drop its own request. The outputs follow the inputs combinationally, with no added cycle.

Top module: `intr_router`

## Requirements
- R1: Status words sit at byte offsets 0x100 (redirectable host), 0x104 (non-redirected host) and 0x108 (management); each bit 0..30 reads as the destination's request source AND the matching mask bit.
- R2: Writing a status word leaves bits 0..30 of every status word as they were; those bits change only with the inputs or the masks.
- R3: A status write with bit 31 = 0 clears that destination's software bit; with bit 31 = 1 it sets the bit on the non-redirected destination always, and on the other two only when their mask bit 31 is 1. The software bit is read in status bit 31.
- R4: Mask words sit at 0x640, 0x644, 0x648 and read back what was written, except that bit 31 of the non-redirected mask (0x644) always reads 0.
- R5: For the non-redirected destination, input positions 0, 5, 6, 7, 12, 15, 16, 17 and 28 (parameter NR_SPLIT) are taken from `hw_irq_nr`; all its other positions, and every position of the other two destinations, are taken from `hw_irq`.
- R6: Enable words sit at 0x140, 0x144, 0x148, holding bit 0 (hardware enable) and bit 1 (software enable), bits 31..2 reading 0; a destination's output is high when (bit 0 and any status bit 0..30 is 1) or (bit 1 and status bit 31 is 1).
- R7: Line-status words at 0x160, 0x164, 0x168 return the current level of the destination's output in bit 0 (1 = asserted) and 0 in bits 31..1; writes to them have no effect.
- R8: After reset all masks, enables and software bits are 0, so every status, mask and enable word reads 0 and all three outputs are low.
- R9: Reads from any address outside the twelve words above return 0, and a write there changes no register.
- R10: Clearing mask bit 31 after the software bit is set does not clear the software bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | 31 | Shared hardware request lines, bit i = source i |
| hw_irq_nr | input | 31 | Private request lines for the non-redirected destination, used only at NR_SPLIT positions |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W (12) | Byte address of the register word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq_host | output | 1 | Redirectable host interrupt line |
| irq_nrhost | output | 1 | Non-redirected host interrupt line |
| irq_mgmt | output | 1 | Management-processor interrupt line |

## Verification
The bench sweeps every enable pairing against hardware-only, software-only, both and neither, on each destination, so a design that swaps the two enable bits or lets a disabled group leak onto a line is caught at the output pins and in the line-status word. It drives different patterns on the shared and private request wires, which exposes a design that feeds the non-redirected destination from the wrong wire at a split position or at an ordinary one. The software-bit sequences cover a set attempt with mask bit 31 clear on each destination, a clear, and a mask drop after a set; a design that applies the mask rule to the non-redirected destination, ignores it elsewhere, or lets the mask gate the stored bit reads back a wrong bit 31. Writes of all ones to status, line-status and unmapped words show whether read-only bits or hidden registers move.

// File: rtl/intr_router.sv
module intr_router #(
  parameter int          ADDR_W   = 12,
  parameter logic [30:0] NR_SPLIT = 31'h100390E1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [30:0]       hw_irq,
  input  logic [30:0]       hw_irq_nr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq_host,
  output logic              irq_nrhost,
  output logic              irq_mgmt
);

  localparam int ND = 3;
  localparam int NR = 1;
  localparam logic [ADDR_W-1:0] STAT_BASE = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] EN_BASE   = ADDR_W'(12'h140);
  localparam logic [ADDR_W-1:0] LINE_BASE = ADDR_W'(12'h160);
  localparam logic [ADDR_W-1:0] MASK_BASE = ADDR_W'(12'h640);

  logic [31:0] mask_q [ND];
  logic [1:0]  en_q   [ND];
  logic        sw_q   [ND];
  logic [30:0] src    [ND];
  logic [31:0] stat   [ND];
  logic [ND-1:0] line;

  logic [1:0] sel;
  logic       sel_ok;
  logic       hit_stat, hit_en, hit_line, hit_mask;

  assign sel    = addr[3:2];
  assign sel_ok = (sel != 2'd3) && (addr[1:0] == 2'd0);

  assign hit_stat = sel_ok && (addr[ADDR_W-1:4] == STAT_BASE[ADDR_W-1:4]);
  assign hit_en   = sel_ok && (addr[ADDR_W-1:4] == EN_BASE[ADDR_W-1:4]);
  assign hit_line = sel_ok && (addr[ADDR_W-1:4] == LINE_BASE[ADDR_W-1:4]);
  assign hit_mask = sel_ok && (addr[ADDR_W-1:4] == MASK_BASE[ADDR_W-1:4]);

  assign src[0]  = hw_irq;
  assign src[NR] = (hw_irq & ~NR_SPLIT) | (hw_irq_nr & NR_SPLIT);
  assign src[2]  = hw_irq;

  for (genvar d = 0; d < ND; d++) begin : g_dest
    localparam bit          IS_NR   = (d == NR);
    localparam logic [31:0] MASK_WR = IS_NR ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
    logic wr_here;

    assign wr_here = wr_en && (sel == 2'(d));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[d] <= '0;
        en_q[d]   <= '0;
        sw_q[d]   <= 1'b0;
      end else if (wr_here) begin
        if (hit_mask) mask_q[d] <= wr_data & MASK_WR;
        if (hit_en)   en_q[d]   <= wr_data[1:0];
        if (hit_stat) begin
          if (!wr_data[31])                sw_q[d] <= 1'b0;
          else if (IS_NR || mask_q[d][31]) sw_q[d] <= 1'b1;
        end
      end
    end

    assign stat[d] = {sw_q[d], src[d] & mask_q[d][30:0]};
    assign line[d] = (en_q[d][0] & (|stat[d][30:0])) | (en_q[d][1] & stat[d][31]);
  end

  assign irq_host   = line[0];
  assign irq_nrhost = line[NR];
  assign irq_mgmt   = line[2];

  always_comb begin
    rd_data = '0;
    if (hit_stat)      rd_data = stat[sel];
    else if (hit_en)   rd_data = {30'd0, en_q[sel]};
    else if (hit_line) rd_data = {31'd0, line[sel]};
    else if (hit_mask) rd_data = mask_q[sel];
  end

endmodule

module intr_router_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic              irq_host,
  input logic              irq_nrhost,
  input logic              irq_mgmt,
  input logic [31:0]       mask0,
  input logic [31:0]       mask1,
  input logic [1:0]        en0,
  input logic              sw0,
  input logic              sw1,
  input logic              sw2
);
  localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] A_STAT1 = ADDR_W'(12'h104);
  localparam logic [ADDR_W-1:0] A_STAT2 = ADDR_W'(12'h108);
  localparam logic [ADDR_W-1:0] A_MASK1 = ADDR_W'(12'h644);

  a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_host && !irq_nrhost && !irq_mgmt));

  a_r3_host_sw_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT0 && wr_data[31] && !mask0[31] && !sw0) |=> !sw0);

  a_r3_nr_sw_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT1 && wr_data[31]) |=> sw1);

  a_r3_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT2 && !wr_data[31]) |=> !sw2);

  a_r4_nr_mask_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK1) |=> (mask1 == ($past(wr_data) & 32'h7FFF_FFFF)));

  a_r6_host_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_host |-> (en0 != 2'b00));

  a_r10_sw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sw0 && !(wr_en && addr == A_STAT0)) |=> sw0);
endmodule

bind intr_router intr_router_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .irq_host(irq_host), .irq_nrhost(irq_nrhost), .irq_mgmt(irq_mgmt),
  .mask0(mask_q[0]), .mask1(mask_q[1]), .en0(en_q[0]),
  .sw0(sw_q[0]), .sw1(sw_q[1]), .sw2(sw_q[2])
);

// File: tb/test_intr_router.sv
module test_intr_router;
  localparam int CLK_PERIOD = 10;
  localparam logic [30:0] SPLIT = 31'h100390E1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] hw_irq = '0;
  logic [30:0] hw_irq_nr = '0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_host, irq_nrhost, irq_mgmt;

  int vectors = 0;
  int errors  = 0;

  logic [31:0] m_mask [3];
  logic [1:0]  m_en   [3];
  logic        m_sw   [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_router i_intr_router (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .hw_irq_nr(hw_irq_nr),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq_host(irq_host), .irq_nrhost(irq_nrhost), .irq_mgmt(irq_mgmt)
  );

  function automatic logic [31:0] exp_stat(input int d);
    logic [30:0] s;
    s = (d == 1) ? ((hw_irq & ~SPLIT) | (hw_irq_nr & SPLIT)) : hw_irq;
    return {m_sw[d], s & m_mask[d][30:0]};
  endfunction

  function automatic logic exp_line(input int d);
    logic [31:0] s;
    s = exp_stat(d);
    return (m_en[d][0] & (|s[30:0])) | (m_en[d][1] & s[31]);
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int d;
    d = int'(a[3:2]);
    if (d == 3 || a[1:0] != 2'd0) return '0;
    case (a[11:4])
      8'h10:   return exp_stat(d);
      8'h14:   return {30'd0, m_en[d]};
      8'h16:   return {31'd0, exp_line(d)};
      8'h64:   return m_mask[d];
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    int k;
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    k = int'(a[3:2]);
    if (k != 3 && a[1:0] == 2'd0) begin
      case (a[11:4])
        8'h64: m_mask[k] = d & ((k == 1) ? 32'h7FFF_FFFF : 32'hFFFF_FFFF);
        8'h14: m_en[k] = d[1:0];
        8'h10: begin
          if (!d[31]) m_sw[k] = 1'b0;
          else if (k == 1 || m_mask[k][31]) m_sw[k] = 1'b1;
        end
        default: ;
      endcase
    end
  endtask

  task automatic rd(input string req, input logic [11:0] a);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rd_data, exp_read(a));
  endtask

  task automatic check_lines(input string req);
    #1;
    check(req, {29'd0, irq_mgmt, irq_nrhost, irq_host},
          {29'd0, exp_line(2), exp_line(1), exp_line(0)});
  endtask

  task automatic all_regs(input string req);
    for (int d = 0; d < 3; d++) begin
      rd(req, 12'h100 + 12'(4*d));
      rd(req, 12'h140 + 12'(4*d));
      rd(req, 12'h160 + 12'(4*d));
      rd(req, 12'h640 + 12'(4*d));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [30:0] pats [6];
    logic [31:0] masks [4];
    pats[0] = 31'h0; pats[1] = 31'h7FFF_FFFF; pats[2] = SPLIT;
    pats[3] = ~SPLIT; pats[4] = 31'h2AAA_AAAA; pats[5] = 31'h0000_0100;
    masks[0] = 32'h0; masks[1] = 32'hFFFF_FFFF; masks[2] = 32'h5555_5555; masks[3] = 32'h8000_0100;
    for (int d = 0; d < 3; d++) begin
      m_mask[d] = '0; m_en[d] = '0; m_sw[d] = 1'b0;
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    all_regs("R8");
    check_lines("R8");

    // R4: mask writability
    for (int d = 0; d < 3; d++) wr(12'h640 + 12'(4*d), 32'hFFFF_FFFF);
    for (int d = 0; d < 3; d++) rd("R4", 12'h640 + 12'(4*d));

    // R1, R5: status composition over masks and input patterns
    for (int mi = 0; mi < 4; mi++) begin
      for (int d = 0; d < 3; d++) wr(12'h640 + 12'(4*d), masks[mi]);
      for (int pi = 0; pi < 6; pi++) begin
        for (int qi = 0; qi < 6; qi++) begin
          @(negedge clk);
          hw_irq = pats[pi]; hw_irq_nr = pats[qi];
          rd("R1", 12'h100);
          rd("R5", 12'h104);
          rd("R1", 12'h108);
        end
      end
    end

    // R2: hardware status bits are read-only
    hw_irq = 31'h0F0F_0F0F; hw_irq_nr = 31'h7000_0001;
    for (int d = 0; d < 3; d++) wr(12'h640 + 12'(4*d), 32'h7FFF_FFFF);
    for (int d = 0; d < 3; d++) begin
      wr(12'h100 + 12'(4*d), 32'h7FFF_FFFF);
      all_regs("R2");
      wr(12'h100 + 12'(4*d), 32'h0000_0000);
      all_regs("R2");
    end

    // R3: software bit set rules, clear, and R10 stickiness
    hw_irq = '0; hw_irq_nr = '0;
    for (int d = 0; d < 3; d++) begin
      wr(12'h640 + 12'(4*d), 32'h0);
      wr(12'h100 + 12'(4*d), 32'h8000_0000);
      rd("R3", 12'h100 + 12'(4*d));
      wr(12'h100 + 12'(4*d), 32'h0);
      rd("R3", 12'h100 + 12'(4*d));
      wr(12'h640 + 12'(4*d), 32'h8000_0000);
      wr(12'h100 + 12'(4*d), 32'h8000_0000);
      rd("R3", 12'h100 + 12'(4*d));
      wr(12'h640 + 12'(4*d), 32'h0);
      rd("R10", 12'h100 + 12'(4*d));
      wr(12'h100 + 12'(4*d), 32'h0);
      rd("R3", 12'h100 + 12'(4*d));
    end

    // R6, R7: output generation and line status over all enable/source combinations
    for (int d = 0; d < 3; d++) wr(12'h640 + 12'(4*d), 32'hFFFF_FFFF);
    for (int en = 0; en < 4; en++) begin
      for (int hw = 0; hw < 2; hw++) begin
        for (int sw = 0; sw < 2; sw++) begin
          for (int d = 0; d < 3; d++) begin
            wr(12'h140 + 12'(4*d), 32'hFFFF_FFFC | 32'(en));
            wr(12'h100 + 12'(4*d), sw ? 32'h8000_0000 : 32'h0);
          end
          @(negedge clk);
          hw_irq = hw ? 31'h0000_1000 : 31'h0;
          hw_irq_nr = hw ? 31'h0000_1000 : 31'h0;
          check_lines("R6");
          for (int d = 0; d < 3; d++) begin
            rd("R6", 12'h140 + 12'(4*d));
            rd("R7", 12'h160 + 12'(4*d));
          end
          @(negedge clk);
          hw_irq = hw ? 31'h0000_0010 : 31'h0;
          hw_irq_nr = 31'h0;
          check_lines("R6");
          rd("R7", 12'h164);
        end
      end
    end

    // R7: line-status writes ignored
    wr(12'h160, 32'h0); wr(12'h164, 32'hFFFF_FFFF);
    all_regs("R7");
    check_lines("R7");

    // R9: unmapped addresses
    wr(12'h10C, 32'hFFFF_FFFF); wr(12'h64C, 32'hFFFF_FFFF);
    wr(12'h642, 32'h0); wr(12'h000, 32'hFFFF_FFFF);
    rd("R9", 12'h10C); rd("R9", 12'h64C); rd("R9", 12'h000);
    rd("R9", 12'h200); rd("R9", 12'h642); rd("R9", 12'h180);
    all_regs("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule